// File: doc/BRIEF.md
# SPI Status Flag and Mode-Fault Unit

This block keeps the status flags of a byte-wide SPI peripheral whose transmit and receive paths are each double-buffered. A shift engine outside the block reports three events: the transmit holding byte was handed to the shifter, a complete byte was received, and a transfer is in progress. The block also watches the select-pin level, the master/slave choice, the enable bit and the fault-detect enable. From these it maintains a receive-overrun flag, a mode-fault flag and a transmit-empty flag. It holds the received byte and the pending transmit byte, raises an interrupt request, and reports whether the peripheral owns the select pin.

Software reaches the block through single-cycle access strobes: status read, receive-data read, control write and transmit-data write. The overrun and mode-fault flags only clear through a two-step sequence. First comes a status read that sees the flag set, then the matching second access. The received-byte input is a valid-only stream with no ready signal. The block accepts every byte, and a byte that arrives while the receive register is still unread is dropped and recorded as an overrun. Control and status pins are plain levels.

Top module: `spi_flag_unit`

## Requirements
- R1: After reset, overrun and mode-fault are 0, transmit-empty is 1, the write-collision pulse is 0, and the receive and transmit byte registers hold 0.
- R2: A byte on `eng_rx_valid` while the receive register is free (or is being read that same cycle) appears on `rx_data_q` one cycle later. A receive-data read frees the register, and `rx_data_q` keeps showing the last byte.
- R3: A byte that arrives while the receive register is unread, with no receive-data read in that cycle, sets the overrun flag. `rx_data_q` keeps the older byte.
- R4: Overrun clears only when a receive-data read follows a status read that saw it set. Idle cycles in between keep the sequence armed. A control write or transmit-data write in between cancels it, and a receive-data read that is not armed leaves the flag set.
- R5: An enabled slave with fault-detect enabled sets mode-fault when the select pin rises while a transfer is in progress. No fault is set when fault-detect is off or when no transfer is in progress.
- R6: An enabled master with fault-detect enabled sets mode-fault in any cycle where the select pin is low. With fault-detect off, the select pin does not affect the master.
- R7: Mode-fault clears only when a control write follows a status read that saw it set. A receive-data read in between cancels the sequence. Turning fault-detect enable off does not clear a set mode-fault.
- R8: When a flag-setting event and that flag's clearing access fall in the same cycle, the flag stays set.
- R9: A transmit-data write while transmit-empty is 1 captures `bus_wdata` into `tx_data_q` and clears transmit-empty. A `eng_tx_load` event sets transmit-empty.
- R10: A transmit-data write while transmit-empty is 0 leaves `tx_data_q` unchanged and drives `wr_collision` high for exactly the next cycle.
- R11: `irq` is high exactly when transmit-empty and `cfg_txie` are both 1.
- R12: `ss_owned` is 0 for an enabled master with fault-detect off and for a disabled peripheral. It is 1 for an enabled master with fault-detect on and for any enabled slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Peripheral enable |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_mfault_en | input | 1 | Mode-fault detection enable |
| cfg_txie | input | 1 | Transmit-empty interrupt enable |
| ss_in | input | 1 | Synchronised select-pin level |
| eng_busy | input | 1 | Transfer in progress |
| eng_tx_load | input | 1 | Holding byte taken by the shifter |
| eng_rx_valid | input | 1 | Received byte valid (no ready, always accepted) |
| eng_rx_data | input | W | Received byte |
| bus_rd_status | input | 1 | Status read strobe |
| bus_rd_rxdata | input | 1 | Receive-data read strobe |
| bus_wr_ctrl | input | 1 | Control write strobe |
| bus_wr_txdata | input | 1 | Transmit-data write strobe |
| bus_wdata | input | W | Write data for transmit write |
| rx_data_q | output | W | Receive data register |
| tx_data_q | output | W | Transmit holding register |
| flag_ovf | output | 1 | Receive overrun flag |
| flag_mfault | output | 1 | Mode-fault flag |
| flag_txe | output | 1 | Transmit-empty flag |
| irq | output | 1 | Interrupt request |
| ss_owned | output | 1 | Peripheral owns the select pin |
| wr_collision | output | 1 | One-cycle pulse for a refused transmit write |

## Verification
Every flag, both byte registers and `wr_collision` are registered, so their result is due one clock edge after the cycle that holds the stimulus. The mode-fault edge detector compares against the select level of the previous cycle, so a slave fault needs the low level in one cycle and the high level in the next. `irq` and `ss_owned` are combinational over registered flags and configuration, so they settle in the cycle the flag or configuration does. The bench drives each stimulus on a falling edge and samples on the next falling edge, which is exactly one rising edge later. It checks `wr_collision` in that cycle and again one cycle later to confirm that it falls.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  typedef enum logic [2:0] {
    ACC_NONE    = 3'd0,
    ACC_RD_STAT = 3'd1,
    ACC_RD_RX   = 3'd2,
    ACC_WR_CTRL = 3'd3,
    ACC_WR_TX   = 3'd4
  } acc_e;

  localparam int NUM_SEQ_FLAGS = 2;
  localparam int IDX_OVF = 0;
  localparam int IDX_MF  = 1;
endpackage

// File: rtl/sfu_flag_reg.sv
module sfu_flag_reg #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= RST_VAL;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R8: set dominates a coincident clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R4/R7: a lone clear drops the flag
  p_clear_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  // R7: a flag only falls after a clear
  p_fall_needs_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> $past(clr_i));
endmodule

// File: rtl/sfu_clear_arm.sv
module sfu_clear_arm
  import sfu_pkg::*;
#(
  parameter acc_e STEP = ACC_RD_RX
) (
  input  logic clk,
  input  logic rst_n,
  input  acc_e acc_i,
  input  logic flag_i,
  output logic clr_o
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else begin
      case (acc_i)
        ACC_NONE:    armed_q <= armed_q;
        ACC_RD_STAT: armed_q <= flag_i;
        default:     armed_q <= 1'b0;
      endcase
    end
  end

  assign clr_o = armed_q && (acc_i == STEP);

  // R4: arming only ever follows a status read
  p_arm_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(acc_i == ACC_RD_STAT));
endmodule

// File: rtl/sfu_rx_hold.sv
module sfu_rx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid_i,
  input  logic [W-1:0] rx_byte_i,
  input  logic         rd_rx_i,
  output logic [W-1:0] rx_data_o,
  output logic         ovf_set_o
);
  logic full_q;
  logic load;

  assign load      = rx_valid_i && (!full_q || rd_rx_i);
  assign ovf_set_o = rx_valid_i && full_q && !rd_rx_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q    <= 1'b0;
      rx_data_o <= '0;
    end else begin
      if (load) begin
        full_q    <= 1'b1;
        rx_data_o <= rx_byte_i;
      end else if (rd_rx_i) begin
        full_q <= 1'b0;
      end
    end
  end

  // R3: an overrun leaves the held byte alone
  p_keep_on_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set_o |=> $stable(rx_data_o));
  // R2: a byte into a free register is captured
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && !full_q) |=> (rx_data_o == $past(rx_byte_i)));
endmodule

// File: rtl/sfu_mode_fault.sv
module sfu_mode_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic master_i,
  input  logic mfen_i,
  input  logic busy_i,
  input  logic ss_i,
  output logic set_o,
  output logic owned_o
);
  logic ss_q;
  logic ss_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ss_q <= 1'b1;
    else        ss_q <= ss_i;
  end

  assign ss_rise = ss_i && !ss_q;
  assign set_o   = en_i && mfen_i && (master_i ? !ss_i : (busy_i && ss_rise));
  assign owned_o = en_i && !(master_i && !mfen_i);

  // R5: a slave never faults while not busy
  p_slave_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_i && !busy_i) |-> !set_o);
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
  import sfu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_enable,
  input  logic         cfg_master,
  input  logic         cfg_mfault_en,
  input  logic         cfg_txie,
  input  logic         ss_in,
  input  logic         eng_busy,
  input  logic         eng_tx_load,
  input  logic         eng_rx_valid,
  input  logic [W-1:0] eng_rx_data,
  input  logic         bus_rd_status,
  input  logic         bus_rd_rxdata,
  input  logic         bus_wr_ctrl,
  input  logic         bus_wr_txdata,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] rx_data_q,
  output logic [W-1:0] tx_data_q,
  output logic         flag_ovf,
  output logic         flag_mfault,
  output logic         flag_txe,
  output logic         irq,
  output logic         ss_owned,
  output logic         wr_collision
);
  localparam acc_e STEPS [NUM_SEQ_FLAGS] = '{ACC_RD_RX, ACC_WR_CTRL};

  acc_e acc;
  logic [NUM_SEQ_FLAGS-1:0] seq_set, seq_clr, seq_flag;
  logic ovf_set, mf_set, tx_accept;

  always_comb begin
    if (bus_rd_status)      acc = ACC_RD_STAT;
    else if (bus_rd_rxdata) acc = ACC_RD_RX;
    else if (bus_wr_ctrl)   acc = ACC_WR_CTRL;
    else if (bus_wr_txdata) acc = ACC_WR_TX;
    else                    acc = ACC_NONE;
  end

  sfu_rx_hold #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid_i(eng_rx_valid), .rx_byte_i(eng_rx_data),
    .rd_rx_i(bus_rd_rxdata), .rx_data_o(rx_data_q), .ovf_set_o(ovf_set)
  );

  sfu_mode_fault u_mf (
    .clk(clk), .rst_n(rst_n), .en_i(cfg_enable), .master_i(cfg_master),
    .mfen_i(cfg_mfault_en), .busy_i(eng_busy), .ss_i(ss_in),
    .set_o(mf_set), .owned_o(ss_owned)
  );

  assign seq_set[IDX_OVF] = ovf_set;
  assign seq_set[IDX_MF]  = mf_set;

  for (genvar g = 0; g < NUM_SEQ_FLAGS; g++) begin : g_seq
    sfu_clear_arm #(.STEP(STEPS[g])) u_arm (
      .clk(clk), .rst_n(rst_n), .acc_i(acc), .flag_i(seq_flag[g]), .clr_o(seq_clr[g])
    );
    sfu_flag_reg #(.RST_VAL(1'b0)) u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(seq_set[g]), .clr_i(seq_clr[g]), .flag_o(seq_flag[g])
    );
  end

  assign flag_ovf    = seq_flag[IDX_OVF];
  assign flag_mfault = seq_flag[IDX_MF];

  assign tx_accept = bus_wr_txdata && flag_txe;

  sfu_flag_reg #(.RST_VAL(1'b1)) u_txe (
    .clk(clk), .rst_n(rst_n), .set_i(eng_tx_load), .clr_i(tx_accept), .flag_o(flag_txe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_data_q    <= '0;
      wr_collision <= 1'b0;
    end else begin
      if (tx_accept) tx_data_q <= bus_wdata;
      wr_collision <= bus_wr_txdata && !flag_txe;
    end
  end

  assign irq = flag_txe && cfg_txie;

  // R4: the register bus issues at most one access per cycle
  p_one_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_rd_status, bus_rd_rxdata, bus_wr_ctrl, bus_wr_txdata}));
  // R10: refused write keeps the holding byte and pulses
  p_collision_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_txdata && !flag_txe) |=> (wr_collision && $stable(tx_data_q)));
  // R9: accepted write empties nothing until the shifter takes it
  p_txe_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_txdata && flag_txe && !eng_tx_load) |=> !flag_txe);
  // R6: master with detection sees a low select as fault
  p_master_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && cfg_master && cfg_mfault_en && !ss_in) |=> flag_mfault);
  // R5: detection off never raises the fault
  p_no_fault_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mfault_en && !flag_mfault) |=> !flag_mfault);
endmodule

// File: tb/test_spi_flag_unit.sv
`timescale 1ns/1ps
module test_spi_flag_unit;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic cfg_enable, cfg_master, cfg_mfault_en, cfg_txie, ss_in, eng_busy;
  logic eng_tx_load, eng_rx_valid;
  logic [W-1:0] eng_rx_data, bus_wdata;
  logic bus_rd_status, bus_rd_rxdata, bus_wr_ctrl, bus_wr_txdata;
  logic [W-1:0] rx_data_q, tx_data_q;
  logic flag_ovf, flag_mfault, flag_txe, irq, ss_owned, wr_collision;

  spi_flag_unit #(.W(W)) i_spi_flag_unit (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_master(cfg_master),
    .cfg_mfault_en(cfg_mfault_en), .cfg_txie(cfg_txie), .ss_in(ss_in), .eng_busy(eng_busy),
    .eng_tx_load(eng_tx_load), .eng_rx_valid(eng_rx_valid), .eng_rx_data(eng_rx_data),
    .bus_rd_status(bus_rd_status), .bus_rd_rxdata(bus_rd_rxdata), .bus_wr_ctrl(bus_wr_ctrl),
    .bus_wr_txdata(bus_wr_txdata), .bus_wdata(bus_wdata), .rx_data_q(rx_data_q),
    .tx_data_q(tx_data_q), .flag_ovf(flag_ovf), .flag_mfault(flag_mfault), .flag_txe(flag_txe),
    .irq(irq), .ss_owned(ss_owned), .wr_collision(wr_collision)
  );

  int n_chk = 0;
  int n_bad = 0;

  // access codes: 0 none, 1 status read, 2 rx read, 3 ctrl write, 4 tx write
  typedef struct packed {
    logic [2:0] acc;
    logic       rxv;
    logic [7:0] rxb;
    logic       txl;
    logic [7:0] wd;
    logic       e_ovf;
    logic       e_txe;
    logic [7:0] e_rx;
    logic [7:0] e_tx;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b1, 8'hA1, 1'b0, 8'h00, 1'b0, 1'b1, 8'hA1, 8'h00}, // R2 load
    '{3'd0, 1'b1, 8'hB2, 1'b0, 8'h00, 1'b1, 1'b1, 8'hA1, 8'h00}, // R3 overrun
    '{3'd2, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 8'hA1, 8'h00}, // R4 unarmed read
    '{3'd0, 1'b1, 8'hC3, 1'b0, 8'h00, 1'b1, 1'b1, 8'hC3, 8'h00}, // R2 reload
    '{3'd1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 8'hC3, 8'h00}, // R4 arm
    '{3'd3, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 8'hC3, 8'h00}, // R4 cancel
    '{3'd2, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 8'hC3, 8'h00}, // R4 no clear
    '{3'd1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 8'hC3, 8'h00}, // R4 arm
    '{3'd0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 8'hC3, 8'h00}, // R4 idle keeps
    '{3'd2, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 8'hC3, 8'h00}, // R4 clear
    '{3'd4, 1'b0, 8'h00, 1'b0, 8'h5A, 1'b0, 1'b0, 8'hC3, 8'h5A}, // R9 accept
    '{3'd4, 1'b0, 8'h00, 1'b0, 8'h77, 1'b0, 1'b0, 8'hC3, 8'h5A}, // R10 refuse
    '{3'd0, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b1, 8'hC3, 8'h5A}, // R9 load
    '{3'd0, 1'b1, 8'hD4, 1'b0, 8'h00, 1'b0, 1'b1, 8'hD4, 8'h5A}  // R2 free again
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    eng_tx_load = 0; eng_rx_valid = 0; eng_rx_data = '0; bus_wdata = '0;
    bus_rd_status = 0; bus_rd_rxdata = 0; bus_wr_ctrl = 0; bus_wr_txdata = 0;
  endtask

  task automatic set_acc(input logic [2:0] a);
    bus_rd_status = (a == 3'd1); bus_rd_rxdata = (a == 3'd2);
    bus_wr_ctrl   = (a == 3'd3); bus_wr_txdata = (a == 3'd4);
  endtask

  task automatic tick();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset();
    idle_inputs();
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cfg_enable = 1; cfg_master = 0; cfg_mfault_en = 0; cfg_txie = 0;
    ss_in = 1; eng_busy = 0;
    do_reset();
    // R1 reset state
    chk("R1 ovf", flag_ovf, 0);
    chk("R1 mfault", flag_mfault, 0);
    chk("R1 txe", flag_txe, 1);
    chk("R1 collision", wr_collision, 0);
    chk("R1 rx", rx_data_q, 0);
    chk("R1 tx", tx_data_q, 0);
    chk("R11 irq off", irq, 0);
    cfg_txie = 1;
    @(negedge clk);
    chk("R11 irq on", irq, 1);

    for (int i = 0; i < NV; i++) begin
      set_acc(VEC[i].acc);
      eng_rx_valid = VEC[i].rxv; eng_rx_data = VEC[i].rxb;
      eng_tx_load = VEC[i].txl;  bus_wdata = VEC[i].wd;
      tick();
      chk($sformatf("R2/R3/R4/R9 vec%0d ovf", i), flag_ovf, VEC[i].e_ovf);
      chk($sformatf("R9 vec%0d txe", i), flag_txe, VEC[i].e_txe);
      chk($sformatf("R2/R3 vec%0d rx", i), rx_data_q, VEC[i].e_rx);
      chk($sformatf("R9/R10 vec%0d tx", i), tx_data_q, VEC[i].e_tx);
    end

    // R10 collision pulse timing, R11 irq follows txe
    set_acc(3'd4); bus_wdata = 8'h11; tick();
    chk("R9 accept tx", tx_data_q, 8'h11);
    chk("R11 irq low", irq, 0);
    chk("R10 no pulse on accept", wr_collision, 0);
    set_acc(3'd4); bus_wdata = 8'h22; tick();
    chk("R10 pulse", wr_collision, 1);
    chk("R10 tx kept", tx_data_q, 8'h11);
    tick();
    chk("R10 pulse ends", wr_collision, 0);

    // R12 ownership
    cfg_master = 1; cfg_mfault_en = 0; @(negedge clk);
    chk("R12 master no detect", ss_owned, 0);
    cfg_mfault_en = 1; @(negedge clk);
    chk("R12 master detect", ss_owned, 1);
    cfg_master = 0; cfg_mfault_en = 0; @(negedge clk);
    chk("R12 slave", ss_owned, 1);
    cfg_enable = 0; @(negedge clk);
    chk("R12 disabled", ss_owned, 0);
    cfg_enable = 1;

    // R6 master ignores select when detection off
    do_reset();
    cfg_master = 1; cfg_mfault_en = 0; ss_in = 0; tick(); tick();
    chk("R6 detect off", flag_mfault, 0);
    cfg_mfault_en = 1; tick();
    chk("R6 low select faults", flag_mfault, 1);

    // R7 clear sequence, enable drop does not clear, cancel by rx read
    ss_in = 1; tick();
    set_acc(3'd1); tick();
    cfg_mfault_en = 0; tick();
    chk("R7 enable drop keeps", flag_mfault, 1);
    set_acc(3'd3); tick();
    chk("R7 cleared", flag_mfault, 0);
    cfg_mfault_en = 1; ss_in = 0; tick();
    ss_in = 1;
    set_acc(3'd1); tick();
    set_acc(3'd2); tick();
    set_acc(3'd3); tick();
    chk("R7 cancelled by rx read", flag_mfault, 1);

    // R8 set wins against coincident clear
    set_acc(3'd1); tick();
    ss_in = 0; set_acc(3'd3); tick();
    chk("R8 set wins", flag_mfault, 1);
    ss_in = 1;

    // R5 slave fault
    do_reset();
    cfg_master = 0; cfg_mfault_en = 0; eng_busy = 1; ss_in = 0; tick();
    ss_in = 1; tick();
    chk("R5 detect off", flag_mfault, 0);
    cfg_mfault_en = 1; eng_busy = 0; ss_in = 0; tick();
    ss_in = 1; tick();
    chk("R5 not busy", flag_mfault, 0);
    eng_busy = 1; ss_in = 0; tick();
    chk("R5 low alone", flag_mfault, 0);
    ss_in = 1; tick();
    chk("R5 rise in transfer", flag_mfault, 1);
    eng_busy = 0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule